// File: doc/BRIEF.md
# Tiled Pattern Rectangle Fill Engine

This engine paints a rectangle of a framebuffer that stores one byte per pixel. The paint comes from a small repeating tile held in an on-chip pattern buffer. A single start pulse captures a job. The job gives the corner of the rectangle, its size, the base address and row pitch of the destination, and the geometry of the tile: an x mask, a y mask and the tile's row pitch in bytes. The engine then writes 32-bit words with byte strobes to a destination memory port until the rectangle is covered.

The tile repeats in both directions by masking. Its phase follows absolute screen coordinates, not the corner of the rectangle, so two fills that touch join without a seam. Each row begins with single-byte writes until the destination address reaches a 4-byte boundary. It continues with full-word writes while four or more pixels remain, and finishes any leftover pixels one byte at a time. Each full word is built by funnel-shifting two consecutive tile words. The tile row length must be a power of two and a multiple of 4 bytes, so both masks are contiguous low-order bit fields.

Top module: `tile_fill_engine`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are low, and no write occurs while `busy` is low.
- R2: A start pulse seen while idle is accepted, and `busy` is high in the next cycle. A start pulse seen while `busy` is high is ignored: the running job, its writes and its timing are unchanged.
- R3: Destination pixel (column i, row r) is at byte address `dst_base + (dst_y + r) * dst_stride + dst_x + i`. No byte outside the rectangle is written.
- R4: The pixel in column i takes tile byte `(dst_x + i) & pat_xmask` of its tile row, so the horizontal phase is locked to screen x.
- R5: Row r reads tile row `(dst_y + r) & pat_ymask`. That row starts at tile byte `row * pat_stride`, and tile byte b is found at buffer word `b >> 2`, lane `b & 3`.
- R6: Bytes are little-endian in a word: byte address a uses lane `a & 3`, in bits `8*(a&3)+7 : 8*(a&3)`. A single-byte write enables exactly one strobe bit, the one for its lane. `wr_addr` is always word-aligned.
- R7: Within a row, single-byte writes are used until the address is 4-byte aligned. Then full words (strobe `4'hF`) are written while at least four pixels remain. Any remainder is written byte by byte.
- R8: Tile reads have one cycle of latency. Each row costs one cycle per single-byte write, one priming cycle plus one cycle per word if it has any full words, and one cycle at the row's end. Consecutive full words go out on consecutive cycles.
- R9: `busy` falls one cycle after the last write. `done` is high for exactly that one cycle, and `busy` is low while `done` is high.
- R10: A job of zero width or zero height makes no writes and never raises `busy`. `done` pulses in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse |
| dst_x | input | CW | Rectangle left column |
| dst_y | input | CW | Rectangle top row |
| width | input | CW | Pixels per row |
| height | input | CW | Number of rows |
| dst_base | input | AW | Destination base byte address |
| dst_stride | input | CW | Destination row pitch in bytes |
| pat_xmask | input | CW | Tile row length in bytes minus one |
| pat_ymask | input | CW | Tile row count minus one |
| pat_stride | input | CW | Tile row pitch in bytes |
| pat_raddr | output | PAW | Tile buffer word address |
| pat_rdata | input | 32 | Tile buffer data, one cycle after the address |
| wr_en | output | 1 | Destination write valid |
| wr_addr | output | AW | Word-aligned destination byte address |
| wr_data | output | 32 | Destination write data |
| wr_strb | output | 4 | Byte-lane enables |
| busy | output | 1 | Job running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result is due in a known cycle after the edge that takes the start pulse. `busy` is due in the first cycle, writes appear one cycle after their tile read, and `done` is due exactly N cycles later, where N is the per-row cycle sum of R8. The bench computes N and the write count from the row geometry alone, before the job starts. It samples every output at the falling edge and counts falling edges from the start edge, so any lost or extra cycle shows up as a mismatch against N. The whole framebuffer model is compared byte by byte with an image rebuilt from R3 to R5 once `done` has been seen.

// File: rtl/tile_fill_engine.sv
module tile_fill_engine #(
  parameter int CW  = 16,
  parameter int AW  = 32,
  parameter int PAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  dst_x,
  input  logic [CW-1:0]  dst_y,
  input  logic [CW-1:0]  width,
  input  logic [CW-1:0]  height,
  input  logic [AW-1:0]  dst_base,
  input  logic [CW-1:0]  dst_stride,
  input  logic [CW-1:0]  pat_xmask,
  input  logic [CW-1:0]  pat_ymask,
  input  logic [CW-1:0]  pat_stride,
  output logic [PAW-1:0] pat_raddr,
  input  logic [31:0]    pat_rdata,
  output logic           wr_en,
  output logic [AW-1:0]  wr_addr,
  output logic [31:0]    wr_data,
  output logic [3:0]     wr_strb,
  output logic           busy,
  output logic           done
);
  typedef enum logic [1:0] {K_NONE, K_BYTE, K_PRIME, K_WORD} kind_t;

  logic [CW-1:0] x_q, y_q, w_q, h_q, stride_q, xm_q, ym_q, ps_q, r_q, i_q;
  logic [AW-1:0] a_q, rowa_q, s1_addr;
  logic          primed_q, busy_q, done_q;
  kind_t         s1_kind, issue;
  logic [1:0]    s1_sel;
  logic [31:0]   cur_q;

  logic [CW-1:0] rem, col, bi, bi4, prow;
  logic [AW-1:0] pbase, rd_byte, start_addr, next_row;
  logic          row_end, last_row, use_byte;
  logic [63:0]   funnel;
  logic [31:0]   lane_byte;

  assign rem      = w_q - i_q;
  assign row_end  = (rem == '0);
  assign last_row = ((r_q + CW'(1)) == h_q);
  assign use_byte = (a_q[1:0] != 2'b00) || (rem < CW'(4));

  always_comb begin
    issue = K_NONE;
    if (busy_q && !row_end)
      issue = use_byte ? K_BYTE : (primed_q ? K_WORD : K_PRIME);
  end

  assign col     = x_q + i_q;
  assign bi      = col & xm_q;
  assign bi4     = (col + CW'(4)) & xm_q;
  assign prow    = (y_q + r_q) & ym_q;
  assign pbase   = AW'(prow) * AW'(ps_q);
  assign rd_byte = pbase + AW'((issue == K_WORD) ? bi4 : bi);
  assign pat_raddr = rd_byte[PAW+1:2];

  assign start_addr = dst_base + AW'(dst_y) * AW'(dst_stride) + AW'(dst_x);
  assign next_row   = rowa_q + AW'(stride_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;  done_q <= 1'b0;  primed_q <= 1'b0;
      s1_kind <= K_NONE;  s1_addr <= '0;  s1_sel <= '0;  cur_q <= '0;
      x_q <= '0; y_q <= '0; w_q <= '0; h_q <= '0; stride_q <= '0;
      xm_q <= '0; ym_q <= '0; ps_q <= '0; r_q <= '0; i_q <= '0;
      a_q <= '0; rowa_q <= '0;
    end else begin
      done_q  <= 1'b0;
      s1_kind <= issue;
      s1_addr <= a_q;
      s1_sel  <= bi[1:0];
      if (s1_kind == K_PRIME || s1_kind == K_WORD) cur_q <= pat_rdata;
      if (!busy_q) begin
        if (start) begin
          x_q <= dst_x;  y_q <= dst_y;  w_q <= width;  h_q <= height;
          stride_q <= dst_stride;  xm_q <= pat_xmask;  ym_q <= pat_ymask;
          ps_q <= pat_stride;
          r_q <= '0;  i_q <= '0;  primed_q <= 1'b0;
          a_q <= start_addr;  rowa_q <= start_addr;
          if (width == '0 || height == '0) done_q <= 1'b1;
          else                              busy_q <= 1'b1;
        end
      end else begin
        unique case (issue)
          K_BYTE:  begin i_q <= i_q + CW'(1); a_q <= a_q + AW'(1); end
          K_PRIME: primed_q <= 1'b1;
          K_WORD:  begin i_q <= i_q + CW'(4); a_q <= a_q + AW'(4); end
          default: begin
            if (last_row) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              r_q <= r_q + CW'(1);  i_q <= '0;  primed_q <= 1'b0;
              rowa_q <= next_row;  a_q <= next_row;
            end
          end
        endcase
      end
    end
  end

  assign funnel    = {pat_rdata, cur_q} >> {s1_sel, 3'b000};
  assign lane_byte = pat_rdata >> {s1_sel, 3'b000};

  assign wr_en   = (s1_kind == K_BYTE) || (s1_kind == K_WORD);
  assign wr_addr = {s1_addr[AW-1:2], 2'b00};
  assign wr_data = (s1_kind == K_WORD) ? funnel[31:0] : {4{lane_byte[7:0]}};
  assign wr_strb = (s1_kind == K_WORD) ? 4'hF
                 : (wr_en ? (4'b0001 << s1_addr[1:0]) : 4'h0);
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/tile_fill_engine_chk.sv
module tile_fill_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [3:0]    wr_strb
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  p_rise_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_strobe_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_strb == 4'hF || $onehot(wr_strb)));

  p_addr_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr[1:0] == 2'b00));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind tile_fill_engine tile_fill_engine_chk #(.AW(AW)) chk_i (.*);

// File: tb/tile_fill_engine_tb.sv
`timescale 1ns/1ps
module tile_fill_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] dst_x = '0, dst_y = '0, width = '0, height = '0;
  logic [31:0] dst_base = '0;
  logic [15:0] dst_stride = '0, pat_xmask = '0, pat_ymask = '0, pat_stride = '0;
  logic [13:0] pat_raddr;
  logic [31:0] pat_rdata = '0;
  logic        wr_en;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_strb;
  logic        busy, done;

  always #2 clk = ~clk;

  tile_fill_engine dut_i (.*);

  logic [31:0] pmem [0:255];
  logic [7:0]  fb   [0:4095];
  logic [7:0]  expv [0:4095];
  int pass_n = 0, total_n = 0, wcount = 0, bad = 0;

  always @(posedge clk) pat_rdata <= pmem[pat_raddr[7:0]];

  function automatic logic [7:0] pbyte(int k);
    logic [31:0] w = pmem[(k >> 2) & 255];
    return w[8*(k & 3) +: 8];
  endfunction

  always @(negedge clk) begin
    if (wr_en) begin
      wcount++;
      if (!(wr_strb == 4'hF || $onehot(wr_strb)) || wr_addr[1:0] != 2'b00) bad++;
      for (int l = 0; l < 4; l++)
        if (wr_strb[l]) fb[(int'(wr_addr[11:0]) + l) & 4095] = wr_data[8*l +: 8];
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en, "R1 reset outputs", {busy, done, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_en, "R1 idle after reset", {busy, wr_en}, 0);
  endtask

  task automatic run_fill(int x, int y, int w, int h, int base, int stride,
                          int xm, int ym, int ps, bit ign, string tag);
    int n_exp = 0, w_exp = 0, cnt = 0, mism = 0, first = -1;
    for (int k = 0; k < 4096; k++) begin fb[k] = 8'hEE; expv[k] = 8'hEE; end
    for (int r = 0; r < h; r++) begin
      int a = base + (y + r) * stride + x;
      int head = (4 - (a & 3)) & 3;
      int rm, wd, tl;
      if (head > w) head = w;
      rm = w - head; wd = rm / 4; tl = rm % 4;
      n_exp += head + (wd > 0 ? wd + 1 : 0) + tl + 1;
      w_exp += head + wd + tl;
      for (int i = 0; i < w; i++)
        expv[(a + i) & 4095] = pbyte(((y + r) & ym) * ps + ((x + i) & xm));
    end
    if (w == 0 || h == 0) n_exp = 0;
    @(negedge clk);
    wcount = 0; bad = 0;
    dst_x = 16'(x); dst_y = 16'(y); width = 16'(w); height = 16'(h);
    dst_base = 32'(base); dst_stride = 16'(stride);
    pat_xmask = 16'(xm); pat_ymask = 16'(ym); pat_stride = 16'(ps);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n_exp > 0) chk(busy, {tag, " R2 busy after start"}, busy, 1);
    else           chk(!busy, {tag, " R10 busy stays low"}, busy, 0);
    while (!done && cnt < 5000) begin
      if (ign && cnt == 3) begin
        dst_base = 32'(base + 2048); dst_x = 16'(x + 1); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    chk(cnt < 5000, {tag, " watchdog R9"}, cnt, n_exp);
    chk(cnt == n_exp, {tag, " R8 cycles to done"}, cnt, n_exp);
    chk(!busy, {tag, " R9 busy low with done"}, busy, 0);
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 done single cycle"}, done, 0);
    for (int k = 0; k < 4096; k++)
      if (fb[k] !== expv[k]) begin mism++; if (first < 0) first = k; end
    if (mism != 0)
      $display("  first mismatch at %0d: got %0h want %0h", first, fb[first], expv[first]);
    chk(mism == 0, {tag, " R3 R4 R5 image"}, mism, 0);
    chk(wcount == w_exp, {tag, " R7 write count"}, wcount, w_exp);
    chk(bad == 0, {tag, " R6 strobe and alignment"}, bad, 0);
  endtask

  initial begin
    for (int k = 0; k < 256; k++)
      for (int b = 0; b < 4; b++)
        pmem[k][8*b +: 8] = 8'(((4*k + b) * 37 + 11) & 255);
    t_reset();
    run_fill(0, 0, 16, 2, 0,   64, 7,  1, 8,  1'b0, "aligned R7");
    run_fill(5, 3, 13, 3, 0,   64, 15, 3, 16, 1'b0, "unaligned R6");
    run_fill(1, 0, 2,  2, 0,   64, 3,  0, 4,  1'b0, "narrow R6");
    run_fill(2, 0, 4,  1, 0,   64, 7,  0, 8,  1'b0, "split word R7");
    run_fill(6, 5, 20, 4, 130, 64, 7,  3, 8,  1'b0, "anchored R4");
    run_fill(4, 1, 24, 3, 0,   64, 31, 1, 32, 1'b1, "restart ignored R2");
    run_fill(3, 2, 0,  5, 0,   64, 7,  1, 8,  1'b0, "zero width R10");
    run_fill(3, 2, 9,  0, 0,   64, 7,  1, 8,  1'b0, "zero height R10");
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total_n++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end
endmodule